// File: doc/BRIEF.md
# Byte-Serial Instruction Register Loader

The block builds a 32-bit instruction word from a byte-wide memory, one byte per fetch cycle. The controller drives a 4-bit slot-enable vector together with a memory address just after each rising edge. The byte that the memory returns is written into the selected byte slot of the instruction register on the next rising edge. Four such steps fill the whole register.

The memory is expected to have registered reads and to be clocked on the falling edge. The address is set up after a rising edge and the memory registers it half a period later. Its data is then valid well before the next rising edge, when the slot captures it. From the controller's side this gives the same timing as a memory with asynchronous reads. The loader itself is a bank of four byte-wide registers with enables. It has no sequencing state: which slot loads on which cycle is decided entirely by the enable vector.

Top module: `ir_byte_loader`

## Requirements
- R1: While `rst_n` is low, `instr` is 32'h0000_0000, independent of every other input.
- R2: `slot_en[0]` high at a rising edge loads `mem_byte` into `instr[7:0]`.
- R3: `slot_en[1]` high at a rising edge loads `mem_byte` into `instr[15:8]`.
- R4: `slot_en[2]` high at a rising edge loads `mem_byte` into `instr[23:16]`.
- R5: `slot_en[3]` high at a rising edge loads `mem_byte` into `instr[31:24]`.
- R6: A byte field whose `slot_en` bit is low at a rising edge keeps its value across that edge.
- R7: With `slot_en` equal to 4'b0000, `instr` holds its value, whatever `mem_byte` does.
- R8: A sequence of four enables 0001, 0010, 0100, 1000 on four consecutive cycles, reading bytes at consecutive addresses from a falling-edge registered memory, leaves `instr` = {byte3, byte2, byte1, byte0}. Byte0 comes from the first address.
- R9: If more than one bit of `slot_en` is high at a rising edge, every selected field loads the same `mem_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the instruction register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_byte | input | 8 | Byte returned by the falling-edge memory |
| slot_en | input | 4 | Per-slot write enable, bit k selects bits 8k+7:8k |
| instr | output | 32 | Assembled instruction word |

## Verification
The hardest case to reach is the half-cycle handoff. The address changes just after a rising edge, the memory updates its output on the falling edge, and the register samples that output on the next rising edge. A mistake in this handoff would capture the byte from the previous address. The bench therefore models a registered-read memory clocked on the falling edge and fills it with distinct bytes. It then runs back-to-back fetches from several base addresses, so a byte taken one step too early or too late produces a different word. Enables with no bit set and with several bits set are applied between the fetches.

// File: rtl/ir_pkg.sv
package ir_pkg;
    localparam int BYTE_W   = 8;
    localparam int SLOT_CNT = 4;
    localparam int WORD_W   = BYTE_W * SLOT_CNT;

    typedef logic [BYTE_W-1:0]   byte_t;
    typedef logic [SLOT_CNT-1:0] slot_mask_t;
    typedef logic [WORD_W-1:0]   word_t;
endpackage

// File: rtl/ir_byte_slot.sv
module ir_byte_slot #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/ir_byte_loader.sv
module ir_byte_loader
    import ir_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   mem_byte,
    input  logic [SLOT_CNT-1:0] slot_en,
    output logic [WORD_W-1:0]   instr
);
    // Slot k owns bits 8k+7:8k; slot 0 is the first byte fetched.
    for (genvar k = 0; k < SLOT_CNT; k++) begin : g_slot
        ir_byte_slot #(.WIDTH(BYTE_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (slot_en[k]),
            .din   (mem_byte),
            .q     (instr[k*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/ir_byte_loader_chk.sv
module ir_byte_loader_chk
    import ir_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [BYTE_W-1:0]   mem_byte,
    input logic [SLOT_CNT-1:0] slot_en,
    input logic [WORD_W-1:0]   instr
);
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (instr == '0)
                else $error("instr not cleared in reset");
        end
    end

    assert_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[0] |=> instr[7:0] == $past(mem_byte));
    assert_byte1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[1] |=> instr[15:8] == $past(mem_byte));
    assert_byte2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[2] |=> instr[23:16] == $past(mem_byte));
    assert_top_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[3] |=> instr[31:24] == $past(mem_byte));

    for (genvar k = 0; k < SLOT_CNT; k++) begin : g_keep
        assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_en[k] |=> $stable(instr[k*BYTE_W +: BYTE_W]));
    end

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en == '0) |=> $stable(instr));

    assert_multi_same_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en[0] && slot_en[3]) |=> instr[7:0] == instr[31:24]);
endmodule

bind ir_byte_loader ir_byte_loader_chk u_chk (.*);

// File: tb/sim_ir_byte_loader.sv
module sim_ir_byte_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_byte = 8'h00;
    logic [3:0]  slot_en = 4'b0000;
    logic [31:0] instr;
    logic [3:0]  addr = 4'd0;
    logic [7:0]  rom [16];
    logic [31:0] model = 32'h0;
    int total = 0;
    int bad = 0;
    string tag = "R1";

    ir_byte_loader u0 (.clk(clk), .rst_n(rst_n), .mem_byte(mem_byte),
                       .slot_en(slot_en), .instr(instr));

    always #2 clk = ~clk;

    // registered-read memory clocked on the falling edge
    always @(negedge clk) mem_byte <= rom[addr];

    // behavioural reference, updated at each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model = 32'h0;
        else for (int k = 0; k < 4; k++) if (slot_en[k]) model[8*k +: 8] = mem_byte;
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) if (rst_n) check(tag, instr, model);

    task automatic step(logic [3:0] en, logic [3:0] a);
        @(posedge clk); #1;
        slot_en = en; addr = a;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        slot_en = 4'b0000;
    endtask

    task automatic fetch(logic [3:0] base);
        tag = "R8";
        for (int s = 0; s < 4; s++) step(4'b0001 << s, base + 4'(s));
        idle();
        @(posedge clk); #1;
        check("R8", instr, {rom[base+4'd3], rom[base+4'd2], rom[base+4'd1], rom[base]});
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rom[i] = 8'(i * 37 + 5);
        slot_en = 4'b1111;
        #7;
        check("R1", instr, 32'h0);
        rst_n = 1'b1;
        // single slots
        tag = "R2"; step(4'b0001, 4'd1); idle(); #1 check("R2", {24'h0, instr[7:0]}, {24'h0, rom[1]});
        tag = "R3"; step(4'b0010, 4'd2); idle(); #1 check("R3", {24'h0, instr[15:8]}, {24'h0, rom[2]});
        tag = "R4"; step(4'b0100, 4'd3); idle(); #1 check("R4", {24'h0, instr[23:16]}, {24'h0, rom[3]});
        tag = "R5"; step(4'b1000, 4'd4); idle(); #1 check("R5", {24'h0, instr[31:24]}, {24'h0, rom[4]});
        // other fields untouched
        tag = "R6"; step(4'b0010, 4'd9); idle(); #1
        check("R6", instr, {rom[4], rom[3], rom[9], rom[1]});
        // idle with changing memory output
        tag = "R7";
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1; slot_en = 4'b0000; addr = 4'(i + 10);
        end
        @(posedge clk); #1;
        check("R7", instr, {rom[4], rom[3], rom[9], rom[1]});
        // full fetches, back to back and from several bases
        fetch(4'd0);
        fetch(4'd5);
        fetch(4'd12);
        // several enables at once
        tag = "R9"; step(4'b1001, 4'd7); idle(); #1
        check("R9", instr, {rom[7], rom[14], rom[13], rom[7]});
        tag = "R9"; step(4'b1111, 4'd6); idle(); #1
        check("R9", instr, {4{rom[6]}});
        // reset in mid-run
        @(posedge clk); #1;
        rst_n = 1'b0; tag = "R1";
        #1 check("R1", instr, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        idle(); idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule